// File: doc/BRIEF.md
# Block-Matching SAD Engine with Partial Distortion Elimination

This block is the distortion stage of an integer-pel motion estimator. A separate stage generates candidate positions and pushes them into a FIFO. This engine pops those positions one at a time. For each one it forms the sum of absolute differences (SAD) between the current block and the matching region of an on-chip search window. It moves eight 8-bit pixels, one 64-bit word, per cycle. It keeps the smallest SAD of the search and the vector that produced it. A candidate is dropped as soon as its running partial sum shows that it cannot win.

Two block shapes are supported. The first is a full 16x16 macroblock. The second is one of its four 8x8 quadrants, used for sub-block refinement. The current macroblock is written into a local buffer over a word-wide port. While that happens, a side adder accumulates the total of all written pixels into a register, which mode-decision logic reads later.

A search is armed with a start pulse. It ends when the candidate flagged as the final one of the search has been resolved, either by running to completion or by being eliminated. The engine then raises its done flag and holds the result until the next start.

Top module: `sad_pde_engine`

## Requirements
- R1: A `cur_clr` pulse without a write sets `pix_sum` to zero on the next cycle. Each `cur_wr_en` cycle adds the sum of the eight bytes of `cur_wr_data` to `pix_sum`. The 16-bit register holds a full block total (256 x 255) exactly.
- R2: On the cycle after `start`, the stored minimum `best_sad` reads all ones (65535), `done` is low and `cand_ready` is high. `blk_mode` and `sub_sel` are sampled in the `start` cycle.
- R3: When `blk_mode` is 0, a candidate at window position (x, y) scores the SAD of all 256 current pixels against window pixels (x+c, y+r). Data packing is as follows. Byte i of a current-buffer word at address `2*r + h` is pixel (row r, column 8h+i). Byte i of a window word at address `y*4 + w` is window pixel (row y, column 8w+i). The engine processes one 8-pixel word per beat in address order, 32 beats in all.
- R4: When `blk_mode` is 1, only the 8x8 quadrant chosen by `sub_sel` is scored. Bit 0 of `sub_sel` selects the right half and bit 1 selects the lower half. Quadrant pixel (b, i) is compared with window pixel (x+i, y+b), over 8 beats.
- R5: The reported result is the candidate with the strictly smallest SAD. When SADs are equal, the candidate accepted earlier is kept. `best_x`/`best_y` are that candidate's position and `best_sad` is its SAD.
- R6: After each beat that is not the last, a candidate whose partial sum is greater than or equal to the current minimum is abandoned. A candidate therefore occupies one accept cycle plus the number of beats actually processed. `done` rises exactly that many cycles (summed over all candidates) after the cycle following `start`.
- R7: `done` rises after the candidate presented with `cand_last` is resolved. From then until the next `start`, `done`, `best_x`, `best_y` and `best_sad` hold, and candidates offered on the input are not taken.
- R8: Accumulation never wraps. A candidate of SAD 65280 is reported as 65280.
- R9: `cand_ready` is high only while a search is armed and no candidate is being scored. It is never high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_clr | input | 1 | Clear the pixel-sum register |
| cur_wr_en | input | 1 | Write one word of the current block |
| cur_wr_addr | input | 5 | Current-block word address (2*row + half) |
| cur_wr_data | input | 64 | Eight current-block pixels |
| pix_sum | output | 16 | Sum of all current-block pixels written since the last clear |
| win_wr_en | input | 1 | Write one word of the search window |
| win_wr_addr | input | 7 | Search-window word address (row*4 + word) |
| win_wr_data | input | 64 | Eight search-window pixels |
| start | input | 1 | Arm a new search and reset the minimum |
| blk_mode | input | 1 | 0: 16x16 block, 1: 8x8 quadrant |
| sub_sel | input | 2 | Quadrant select in 8x8 mode |
| cand_valid | input | 1 | FIFO holds a candidate |
| cand_x | input | 5 | Candidate column in the window |
| cand_y | input | 5 | Candidate row in the window |
| cand_last | input | 1 | This candidate is the final one of the search |
| cand_ready | output | 1 | Engine pops the candidate this cycle |
| best_x | output | 5 | Column of the best candidate |
| best_y | output | 5 | Row of the best candidate |
| best_sad | output | 16 | SAD of the best candidate |
| done | output | 1 | Search finished, result valid |

## Verification
The bench sweeps dense grids of candidates over a hashed window for the macroblock and for every quadrant. In each sweep it plants a near-match, so a design that mis-addresses a quadrant or a beat reports the wrong vector or SAD. It recomputes the elimination schedule itself and compares the cycle at which `done` rises. An elimination test of `>` instead of `>=`, or no elimination at all, changes that count, even though the winning vector is unaffected. A window of zeros against a block of 255s catches wrap in the accumulator and a minimum not preset to all ones. The same window also yields equal SADs, so keeping a later tie shows up as the wrong vector. A second search whose best SAD is larger than the first search's exposes a minimum that is not reset by `start`.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int PIX_W  = 8;
  localparam int LANES  = 8;
  localparam int WORD_W = PIX_W * LANES;
  localparam int RSAD_W = PIX_W + $clog2(LANES);

  typedef logic [WORD_W-1:0] pix_word_t;

  typedef enum logic {
    BLK_MB16 = 1'b0,
    BLK_SUB8 = 1'b1
  } blk_mode_e;

  function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a,
                                                 input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // Sum of |a_i - b_i| over the eight lanes of one word
  function automatic logic [RSAD_W-1:0] word_sad(input pix_word_t a, input pix_word_t b);
    logic [RSAD_W-1:0] s;
    s = '0;
    for (int i = 0; i < LANES; i++)
      s = s + RSAD_W'(abs_diff(a[i*PIX_W +: PIX_W], b[i*PIX_W +: PIX_W]));
    return s;
  endfunction

  // Sum of the eight lanes of one word
  function automatic logic [RSAD_W-1:0] word_sum(input pix_word_t a);
    logic [RSAD_W-1:0] s;
    s = '0;
    for (int i = 0; i < LANES; i++)
      s = s + RSAD_W'(a[i*PIX_W +: PIX_W]);
    return s;
  endfunction
endpackage

// File: rtl/sad_cur_buf.sv
module sad_cur_buf
  import sad_pkg::*;
#(
  parameter int BLK   = 16,
  parameter int SUM_W = 16,
  localparam int WORDS = BLK * BLK / LANES,
  localparam int CAW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [CAW-1:0]   wr_addr,
  input  pix_word_t        wr_data,
  input  logic [CAW-1:0]   rd_addr,
  output pix_word_t        rd_data,
  output logic [SUM_W-1:0] pix_sum
);
  pix_word_t        mem [WORDS];
  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] word_tot;

  assign word_tot = SUM_W'(word_sum(wr_data));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  // Side accumulator: a clear restarts the total, a write in the same cycle seeds it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (clr)    sum_q <= wr_en ? word_tot : '0;
    else if (wr_en)  sum_q <= sum_q + word_tot;
  end

  assign pix_sum = sum_q;
endmodule

// File: rtl/sad_win_mem.sv
module sad_win_mem
  import sad_pkg::*;
#(
  parameter int WIN_W = 32,
  parameter int WIN_H = 32,
  localparam int XW    = $clog2(WIN_W),
  localparam int YW    = $clog2(WIN_H),
  localparam int DEPTH = WIN_W * WIN_H,
  localparam int AW    = $clog2(DEPTH),
  localparam int WAW   = $clog2(DEPTH / LANES)
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [WAW-1:0] wr_addr,
  input  pix_word_t      wr_data,
  input  logic [XW-1:0]  rd_x,
  input  logic [YW-1:0]  rd_y,
  output pix_word_t      rd_data
);
  logic [PIX_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_base;

  assign wr_base = {wr_addr, {$clog2(LANES){1'b0}}};

  always_ff @(posedge clk) begin
    if (wr_en)
      for (int i = 0; i < LANES; i++)
        mem[wr_base + AW'(i)] <= wr_data[i*PIX_W +: PIX_W];
  end

  // Unaligned eight-pixel read; the column index wraps inside the row
  for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
    logic [XW-1:0] col;
    assign col = rd_x + XW'(g);
    assign rd_data[g*PIX_W +: PIX_W] = mem[{rd_y, col}];
  end
endmodule

// File: rtl/sad_pde_core.sv
module sad_pde_core
  import sad_pkg::*;
#(
  parameter int BLK   = 16,
  parameter int WIN_W = 32,
  parameter int WIN_H = 32,
  parameter int SAD_W = 16,
  localparam int XW     = $clog2(WIN_W),
  localparam int YW     = $clog2(WIN_H),
  localparam int HB     = BLK / 2,
  localparam int WPR    = BLK / LANES,
  localparam int NB_MB  = BLK * BLK / LANES,
  localparam int NB_SUB = HB * HB / LANES,
  localparam int BW     = $clog2(NB_MB),
  localparam int CAW    = $clog2(NB_MB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_i,
  input  logic [1:0]       sel_i,
  input  logic             cand_valid,
  input  logic [XW-1:0]    cand_x,
  input  logic [YW-1:0]    cand_y,
  input  logic             cand_last,
  output logic             cand_ready,
  output logic [XW-1:0]    win_x,
  output logic [YW-1:0]    win_y,
  input  pix_word_t        win_data,
  output logic [CAW-1:0]   cur_addr,
  input  pix_word_t        cur_data,
  output logic [XW-1:0]    best_x,
  output logic [YW-1:0]    best_y,
  output logic [SAD_W-1:0] best_sad,
  output logic             done,
  output logic             busy,
  output logic             win_evt,
  output logic             elim_evt,
  output logic [SAD_W-1:0] acc_cur,
  output logic [SAD_W-1:0] acc_next
);
  logic             run_q, act_q, last_q, done_q;
  blk_mode_e        mode_q;
  logic [1:0]       sel_q;
  logic [XW-1:0]    cx_q, bx_q;
  logic [YW-1:0]    cy_q, by_q;
  logic [BW-1:0]    beat_q;
  logic [SAD_W-1:0] acc_q, min_q, acc_nxt;
  logic             last_beat, resolve, accept;
  int               r_cur, c_cur, r_win, c_win;

  // Beat geometry: which current word and which window word this beat compares
  always_comb begin
    if (mode_q == BLK_MB16) begin
      r_cur = int'(beat_q) / WPR;
      c_cur = (int'(beat_q) % WPR) * LANES;
      r_win = r_cur;
      c_win = c_cur;
    end else begin
      r_cur = int'(sel_q[1]) * HB + int'(beat_q);
      c_cur = int'(sel_q[0]) * HB;
      r_win = int'(beat_q);
      c_win = 0;
    end
  end

  assign cur_addr = CAW'(r_cur * WPR + c_cur / LANES);
  assign win_x    = XW'(int'(cx_q) + c_win);
  assign win_y    = YW'(int'(cy_q) + r_win);

  assign last_beat = (mode_q == BLK_MB16) ? (beat_q == BW'(NB_MB - 1))
                                          : (beat_q == BW'(NB_SUB - 1));
  assign acc_nxt   = acc_q + SAD_W'(word_sad(cur_data, win_data));
  assign win_evt   = act_q && last_beat && (acc_nxt < min_q);
  assign elim_evt  = act_q && !last_beat && (acc_nxt >= min_q);
  assign resolve   = act_q && (last_beat || (acc_nxt >= min_q));
  assign cand_ready = run_q && !act_q;
  assign accept    = cand_valid && cand_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      act_q  <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= BLK_MB16;
      sel_q  <= '0;
      cx_q   <= '0;
      cy_q   <= '0;
      bx_q   <= '0;
      by_q   <= '0;
      beat_q <= '0;
      acc_q  <= '0;
      min_q  <= '1;
    end else if (start) begin
      run_q  <= 1'b1;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      min_q  <= '1;
      bx_q   <= '0;
      by_q   <= '0;
      mode_q <= blk_mode_e'(mode_i);
      sel_q  <= sel_i;
    end else if (act_q) begin
      if (resolve) begin
        act_q <= 1'b0;
        if (win_evt) begin
          min_q <= acc_nxt;
          bx_q  <= cx_q;
          by_q  <= cy_q;
        end
        if (last_q) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        acc_q  <= acc_nxt;
        beat_q <= beat_q + 1'b1;
      end
    end else if (accept) begin
      act_q  <= 1'b1;
      cx_q   <= cand_x;
      cy_q   <= cand_y;
      last_q <= cand_last;
      beat_q <= '0;
      acc_q  <= '0;
    end
  end

  assign best_x   = bx_q;
  assign best_y   = by_q;
  assign best_sad = min_q;
  assign done     = done_q;
  assign busy     = act_q;
  assign acc_cur  = acc_q;
  assign acc_next = acc_nxt;
endmodule

// File: rtl/sad_pde_engine.sv
module sad_pde_engine
  import sad_pkg::*;
#(
  parameter int BLK   = 16,
  parameter int WIN_W = 32,
  parameter int WIN_H = 32,
  parameter int SAD_W = 16,
  localparam int XW   = $clog2(WIN_W),
  localparam int YW   = $clog2(WIN_H),
  localparam int CAW  = $clog2(BLK * BLK / LANES),
  localparam int WAW  = $clog2(WIN_W * WIN_H / LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur_clr,
  input  logic             cur_wr_en,
  input  logic [CAW-1:0]   cur_wr_addr,
  input  logic [63:0]      cur_wr_data,
  output logic [SAD_W-1:0] pix_sum,
  input  logic             win_wr_en,
  input  logic [WAW-1:0]   win_wr_addr,
  input  logic [63:0]      win_wr_data,
  input  logic             start,
  input  logic             blk_mode,
  input  logic [1:0]       sub_sel,
  input  logic             cand_valid,
  input  logic [XW-1:0]    cand_x,
  input  logic [YW-1:0]    cand_y,
  input  logic             cand_last,
  output logic             cand_ready,
  output logic [XW-1:0]    best_x,
  output logic [YW-1:0]    best_y,
  output logic [SAD_W-1:0] best_sad,
  output logic             done
);
  pix_word_t        cur_rd, win_rd;
  logic [CAW-1:0]   cur_rd_addr;
  logic [XW-1:0]    rd_x;
  logic [YW-1:0]    rd_y;
  logic             busy, win_evt, elim_evt;
  logic [SAD_W-1:0] acc_q, acc_nxt;

  sad_cur_buf #(.BLK(BLK), .SUM_W(SAD_W)) u_cur (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cur_clr),
    .wr_en   (cur_wr_en),
    .wr_addr (cur_wr_addr),
    .wr_data (cur_wr_data),
    .rd_addr (cur_rd_addr),
    .rd_data (cur_rd),
    .pix_sum (pix_sum)
  );

  sad_win_mem #(.WIN_W(WIN_W), .WIN_H(WIN_H)) u_win (
    .clk     (clk),
    .wr_en   (win_wr_en),
    .wr_addr (win_wr_addr),
    .wr_data (win_wr_data),
    .rd_x    (rd_x),
    .rd_y    (rd_y),
    .rd_data (win_rd)
  );

  sad_pde_core #(.BLK(BLK), .WIN_W(WIN_W), .WIN_H(WIN_H), .SAD_W(SAD_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_i     (blk_mode),
    .sel_i      (sub_sel),
    .cand_valid (cand_valid),
    .cand_x     (cand_x),
    .cand_y     (cand_y),
    .cand_last  (cand_last),
    .cand_ready (cand_ready),
    .win_x      (rd_x),
    .win_y      (rd_y),
    .win_data   (win_rd),
    .cur_addr   (cur_rd_addr),
    .cur_data   (cur_rd),
    .best_x     (best_x),
    .best_y     (best_y),
    .best_sad   (best_sad),
    .done       (done),
    .busy       (busy),
    .win_evt    (win_evt),
    .elim_evt   (elim_evt),
    .acc_cur    (acc_q),
    .acc_next   (acc_nxt)
  );
endmodule

// File: rtl/sad_pde_chk.sv
module sad_pde_chk #(
  parameter int SAD_W = 16,
  parameter int XW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cand_ready,
  input logic             done,
  input logic             busy,
  input logic [SAD_W-1:0] best_sad,
  input logic [XW-1:0]    best_x,
  input logic             win_evt,
  input logic             elim_evt,
  input logic [SAD_W-1:0] acc_q,
  input logic [SAD_W-1:0] acc_nxt,
  input logic             cur_clr,
  input logic             cur_wr_en,
  input logic [SAD_W-1:0] pix_sum
);
  // R1
  pix_sum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_clr && !cur_wr_en) |=> (pix_sum == '0));

  // R2
  start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cand_ready && !done && (&best_sad)));

  // R5
  win_lowers_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_evt && !start) |=> (best_sad < $past(best_sad)));

  // R6
  elim_keeps_best_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elim_evt && !start) |=> ($stable(best_sad) && $stable(best_x)));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(best_sad) && $stable(best_x)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (acc_nxt >= acc_q));

  // R9
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_ready |-> (!done && !busy));
endmodule

bind sad_pde_engine sad_pde_chk #(.SAD_W(SAD_W), .XW(XW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .cand_ready (cand_ready),
  .done       (done),
  .busy       (busy),
  .best_sad   (best_sad),
  .best_x     (best_x),
  .win_evt    (win_evt),
  .elim_evt   (elim_evt),
  .acc_q      (acc_q),
  .acc_nxt    (acc_nxt),
  .cur_clr    (cur_clr),
  .cur_wr_en  (cur_wr_en),
  .pix_sum    (pix_sum)
);

// File: tb/sad_pde_engine_bench.sv
`timescale 1ns/1ps
module sad_pde_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cur_clr = 1'b0, cur_wr_en = 1'b0;
  logic [4:0]  cur_wr_addr = '0;
  logic [63:0] cur_wr_data = '0;
  logic [15:0] pix_sum;
  logic        win_wr_en = 1'b0;
  logic [6:0]  win_wr_addr = '0;
  logic [63:0] win_wr_data = '0;
  logic        start = 1'b0, blk_mode = 1'b0;
  logic [1:0]  sub_sel = '0;
  logic        cand_valid = 1'b0, cand_last = 1'b0;
  logic [4:0]  cand_x = '0, cand_y = '0;
  logic        cand_ready;
  logic [4:0]  best_x, best_y;
  logic [15:0] best_sad;
  logic        done;

  always #4 clk = ~clk;

  sad_pde_engine u_sad_pde_engine (
    .clk(clk), .rst_n(rst_n), .cur_clr(cur_clr), .cur_wr_en(cur_wr_en),
    .cur_wr_addr(cur_wr_addr), .cur_wr_data(cur_wr_data), .pix_sum(pix_sum),
    .win_wr_en(win_wr_en), .win_wr_addr(win_wr_addr), .win_wr_data(win_wr_data),
    .start(start), .blk_mode(blk_mode), .sub_sel(sub_sel),
    .cand_valid(cand_valid), .cand_x(cand_x), .cand_y(cand_y), .cand_last(cand_last),
    .cand_ready(cand_ready), .best_x(best_x), .best_y(best_y),
    .best_sad(best_sad), .done(done)
  );

  int checks = 0, errors = 0;
  int wm [32][32];
  int cm [16][16];
  int cxs [200];
  int cys [200];
  int ncand = 0;
  int exp_x, exp_y, exp_sad, exp_t;

  task automatic check(input string req, input string what, input int got, input int want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, want);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic fill_win_hash(input int seed);
    for (int y = 0; y < 32; y++)
      for (int x = 0; x < 32; x++)
        wm[y][x] = (x * 73 + y * 151 + ((x * y) % 7) * 29 + seed * 17) % 256;
  endtask

  task automatic plant_cur(input int px, input int py);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        cm[r][c] = wm[py + r][px + c] + ((r * 3 + c) % 4);
        if (cm[r][c] > 255) cm[r][c] = 255;
      end
  endtask

  task automatic load_win();
    for (int y = 0; y < 32; y++)
      for (int w = 0; w < 4; w++) begin
        @(negedge clk);
        win_wr_en = 1'b1;
        win_wr_addr = 7'(y * 4 + w);
        for (int i = 0; i < 8; i++) win_wr_data[i*8 +: 8] = 8'(wm[y][w*8 + i]);
      end
    @(negedge clk);
    win_wr_en = 1'b0;
  endtask

  task automatic load_cur();
    for (int r = 0; r < 16; r++)
      for (int h = 0; h < 2; h++) begin
        @(negedge clk);
        cur_wr_en = 1'b1;
        cur_wr_addr = 5'(r * 2 + h);
        for (int i = 0; i < 8; i++) cur_wr_data[i*8 +: 8] = 8'(cm[r][h*8 + i]);
      end
    @(negedge clk);
    cur_wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    cur_clr = 1'b1;
    @(negedge clk);
    cur_clr = 1'b0;
  endtask

  function automatic int cur_total();
    int s = 0;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) s += cm[r][c];
    return s;
  endfunction

  function automatic int beat_sad(input int mode, input int sel, input int x, input int y, input int b);
    int s = 0;
    int rr, c0, wr, wc0;
    if (mode == 0) begin
      rr = b / 2; c0 = (b % 2) * 8; wr = y + rr; wc0 = x + c0;
    end else begin
      rr = (sel / 2) * 8 + b; c0 = (sel % 2) * 8; wr = y + b; wc0 = x;
    end
    for (int i = 0; i < 8; i++) s += absi(cm[rr][c0 + i] - wm[wr][wc0 + i]);
    return s;
  endfunction

  task automatic model(input int mode, input int sel);
    int nb = (mode == 0) ? 32 : 8;
    exp_sad = 65535; exp_x = 0; exp_y = 0; exp_t = 0;
    for (int k = 0; k < ncand; k++) begin
      int acc = 0;
      int used = 0;
      for (int b = 0; b < nb; b++) begin
        acc += beat_sad(mode, sel, cxs[k], cys[k], b);
        used = b + 1;
        if (b == nb - 1) begin
          if (acc < exp_sad) begin exp_sad = acc; exp_x = cxs[k]; exp_y = cys[k]; end
        end else if (acc >= exp_sad) break;
      end
      exp_t += 1 + used;
    end
  endtask

  task automatic add_cand(input int x, input int y);
    cxs[ncand] = x; cys[ncand] = y; ncand++;
  endtask

  task automatic add_grid(input int step, input int maxc);
    for (int y = 0; y <= maxc; y += step)
      for (int x = 0; x <= maxc; x += step) add_cand(x, y);
  endtask

  task automatic run_search(input int mode, input int sel, input string req);
    int idx = 0;
    int j = 1;
    int tdone = -1;
    bit rp = 1'b0;
    model(mode, sel);
    @(negedge clk);
    start = 1'b1; blk_mode = mode[0]; sub_sel = 2'(sel);
    @(negedge clk);
    start = 1'b0;
    check("R2", "minimum preset after start", int'(best_sad), 65535);
    check("R2", "ready/done after start", int'({cand_ready, done}), 2);
    while (tdone < 0 && j < 20000) begin
      if (cand_valid && rp) idx++;
      if (idx < ncand) begin
        cand_valid = 1'b1;
        cand_x = 5'(cxs[idx]);
        cand_y = 5'(cys[idx]);
        cand_last = (idx == ncand - 1);
      end else cand_valid = 1'b0;
      rp = cand_ready;
      if (done) tdone = j;
      else begin @(negedge clk); j++; end
    end
    cand_valid = 1'b0;
    check({req, " R6"}, "cycles until done", tdone, exp_t + 1);
    check({req, " R5"}, "best_x", int'(best_x), exp_x);
    check({req, " R5"}, "best_y", int'(best_y), exp_y);
    check({req, " R5"}, "best_sad", int'(best_sad), exp_sad);
    check("R9", "ready low once done", int'(cand_ready), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset ready", int'(cand_ready), 0);
    check("R7", "reset done", int'(done), 0);
    check("R1", "reset pix_sum", int'(pix_sum), 0);
    rst_n = 1'b1;

    // R1: side sum during loading, clear, reload
    fill_win_hash(1);
    load_win();
    plant_cur(6, 9);
    pulse_clr();
    load_cur();
    check("R1", "pix_sum after load", int'(pix_sum), cur_total());
    pulse_clr();
    check("R1", "pix_sum after clear", int'(pix_sum), 0);
    load_cur();
    check("R1", "pix_sum after reload", int'(pix_sum), cur_total());

    // R3: macroblock sweep with a planted near-match
    ncand = 0; add_grid(2, 16); add_cand(6, 9);
    run_search(0, 0, "R3");
    check("R3", "planted vector found", int'(best_x) * 32 + int'(best_y), 6 * 32 + 9);

    // R4: every quadrant
    for (int s = 0; s < 4; s++) begin
      ncand = 0; add_grid(2, 24); add_cand(6 + (s % 2) * 8, 9 + (s / 2) * 8);
      run_search(1, s, "R4");
      check("R4", "quadrant planted vector", int'(best_x) * 32 + int'(best_y),
            (6 + (s % 2) * 8) * 32 + 9 + (s / 2) * 8);
    end

    // R2: minimum reset by start; second search only far candidates
    ncand = 0; add_cand(0, 0); add_cand(16, 16); add_cand(16, 0);
    run_search(0, 0, "R2");

    // R7: result held, offered candidates ignored after done
    @(negedge clk);
    cand_valid = 1'b1; cand_x = 5'd6; cand_y = 5'd9; cand_last = 1'b1;
    repeat (6) @(negedge clk);
    cand_valid = 1'b0;
    check("R7", "done held", int'(done), 1);
    check("R7", "best_sad held", int'(best_sad), exp_sad);
    check("R7", "best_x held", int'(best_x), exp_x);

    // R8 and tie rule: zero window against a block of 255s
    for (int y = 0; y < 32; y++) for (int x = 0; x < 32; x++) wm[y][x] = 0;
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) cm[r][c] = 255;
    load_win();
    pulse_clr();
    load_cur();
    check("R1", "full-scale pix_sum", int'(pix_sum), 65280);
    ncand = 0; add_cand(3, 1); add_cand(5, 4); add_cand(0, 0);
    run_search(0, 0, "R8");
    check("R8", "full-scale SAD", int'(best_sad), 65280);
    check("R5", "tie keeps earlier x", int'(best_x), 3);
    check("R5", "tie keeps earlier y", int'(best_y), 1);

    // R4 tie in quadrant mode, second candidate equal
    ncand = 0; add_cand(20, 2); add_cand(1, 1);
    run_search(1, 3, "R4");
    check("R5", "quadrant tie", int'(best_x), 20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule